// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets a host reach a bank of byte-wide configuration registers over three pins: an active-low select, a serial clock and one data line used in both directions. Each access is a 16-bit frame. The host first sends a 7-bit register address and then a direction flag. After that, either the host sends eight write bits or the slave sends back eight read bits. Both the address and the data travel most significant bit first. The host changes the data line on the falling clock edge, and the slave samples it on the rising edge. For a read, the slave turns the line around: it begins driving on the falling edge that follows the direction flag.

The block runs in a single system clock domain. It passes the three pins through synchronizers and finds the serial clock edges by oversampling, so the serial clock must be much slower than the system clock. The data pin is split into a sampled input, an output value and an output enable. Register 0x00 is the control register. Its bit 0 puts the output in open-drain mode, in which the slave only pulls the line low. Its bit 7 is a self-clearing software reset that returns every register to its reset value.

Top module: `spi3w_slave`

## Requirements
- R1: A frame is 7 address bits sent most significant bit first, then a direction bit (1 = read, 0 = write), then 8 data bits sent most significant bit first, all sampled on rising serial clock edges.
- R2: On a write, the addressed register takes the 8 data bits once the sixteenth bit has been sampled with select still low.
- R3: On a read, the slave drives D7 to D0 onto the data line. It launches each bit on a falling clock edge, beginning with the falling edge after the direction bit, so that each bit is valid at the next rising edge. In push-pull mode the output enable stays asserted through the whole read data phase.
- R4: The output enable stays deasserted during the address and direction bits, during write data, and whenever select is high.
- R5: Raising select cancels the frame in progress. The next frame starts from the first address bit, and a write cut short leaves its register unchanged.
- R6: Toggling select, and clocking while select is high, does not change any register.
- R7: When control bit 0 is 1 (open-drain mode), the output enable is asserted only for 0 bits, with the output value at 0. A 1 bit is sent by releasing the line. Control bit 0 reads back as written.
- R8: Writing 1 to control bit 7 returns all registers to their reset values: control 0x00, and general registers (addresses 1 to N_REGS-1) 0xA5. Bit 7 always reads back as 0.
- R9: Addresses at or above N_REGS (default 4) read back as 0x00 and ignore writes. They do not alias implemented registers.
- R10: The synchronous reset deasserts the output enable and loads the register reset values given in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| ssel_n_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Sampled level of the shared data line |
| sdio_o | output | 1 | Value the slave puts on the data line |
| sdio_oe | output | 1 | Output enable for the data line |

## Verification
The hardest condition to reach from the pins is a frame cut off at an arbitrary bit. The stimulus must prove both that the shift counter restarts and that a partial write never lands. The bench's frame task takes a stop index, so it can raise select after 3 address bits or after 12 of 16 write bits. Full frames then follow, and the scoreboard checks them against a register model that was never updated by the aborted frame. Open-drain reads are checked bit by bit against a pulled-up line model, so a driven 1 or a missing pull-down shows up as a wrong byte or as a failed drive check.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  // Control register bit positions at address 0
  localparam int OD_BIT   = 0;
  localparam int SRST_BIT = 7;

  // Order of the synchronized pin vector
  localparam int PIN_SDI  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SEL  = 2;
  localparam int PIN_N    = 3;

  typedef struct packed {
    logic drive;
    logic bit_val;
  } tx_req_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
module spi3w_frame
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME = ADDR_W + 1 + DATA_W,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output tx_req_t           tx_req,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam int SH_W = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
  localparam logic [CNT_W-1:0] RW_IDX   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] RD_FIRST = CNT_W'(ADDR_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              rd_mode_q;
  logic              drive_q;
  logic              wr_en_q;
  logic [SH_W-1:0]   sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic              tx_bit_q;
  logic [DATA_W-1:0] wr_data_q;

  logic take_rise, take_fall;
  assign take_rise = sel_act && sclk_rise;
  assign take_fall = sel_act && sclk_fall && rd_mode_q && (cnt_q >= RD_FIRST);

  // Control state: cleared by reset or by select going high
  always_ff @(posedge clk) begin
    if (rst || !sel_act) begin
      cnt_q     <= '0;
      rd_mode_q <= 1'b0;
      drive_q   <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (sclk_rise) begin
        if (cnt_q == RW_IDX) rd_mode_q <= sdi;
        if (cnt_q == LAST_IDX) begin
          cnt_q     <= '0;
          rd_mode_q <= 1'b0;
          drive_q   <= 1'b0;
          wr_en_q   <= !rd_mode_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (take_fall) begin
        drive_q <= 1'b1;
      end
    end
  end

  // Datapath registers: no reset needed
  always_ff @(posedge clk) begin
    if (take_rise) begin
      sh_q <= {sh_q[SH_W-2:0], sdi};
      if (cnt_q == RW_IDX) begin
        addr_q  <= sh_q[ADDR_W-1:0];
        tx_sh_q <= rd_data;
      end
      if (cnt_q == LAST_IDX) wr_data_q <= {sh_q[DATA_W-2:0], sdi};
    end else if (take_fall) begin
      tx_bit_q <= tx_sh_q[DATA_W-1];
      tx_sh_q  <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign rd_addr        = sh_q[ADDR_W-1:0];
  assign wr_en          = wr_en_q;
  assign wr_addr        = addr_q;
  assign wr_data        = wr_data_q;
  assign tx_req.drive   = drive_q;
  assign tx_req.bit_val = tx_bit_q;
  assign bit_cnt        = cnt_q;
endmodule

// File: rtl/spi3w_regs.sv
module spi3w_regs
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int N_REGS = 4,
  parameter logic [DATA_W-1:0] GP_RST = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              od_en
);
  logic [N_REGS*DATA_W-1:0] gp_flat;
  logic ctl_wr, soft_rst, od_q;

  assign ctl_wr   = wr_en && (wr_addr == '0);
  assign soft_rst = ctl_wr && wr_data[SRST_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) od_q <= 1'b0;
    else if (ctl_wr)     od_q <= wr_data[OD_BIT];
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    if (i == 0) begin : g_ctl_slot
      assign gp_flat[DATA_W-1:0] = '0;
    end else begin : g_gp
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst || soft_rst) r_q <= GP_RST;
        else if (wr_en && wr_addr == ADDR_W'(i)) r_q <= wr_data;
      end
      assign gp_flat[i*DATA_W +: DATA_W] = r_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[OD_BIT] = od_q;
    end else begin
      for (int i = 1; i < N_REGS; i++)
        if (rd_addr == ADDR_W'(i)) rd_data = gp_flat[i*DATA_W +: DATA_W];
    end
  end

  assign od_en = od_q;
endmodule

// File: rtl/spi3w_pad.sv
module spi3w_pad
  import spi3w_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    od_en,
  input  tx_req_t tx_req,
  output logic    pad_o,
  output logic    pad_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
    end else if (od_en) begin
      pad_o  <= 1'b0;
      pad_oe <= tx_req.drive && !tx_req.bit_val;
    end else begin
      pad_o  <= tx_req.bit_val;
      pad_oe <= tx_req.drive;
    end
  end
endmodule

// File: rtl/spi3w_slave.sv
module spi3w_slave
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int N_REGS = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] GP_RST = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic ssel_n_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe
);
  localparam int FRAME = ADDR_W + 1 + DATA_W;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [PIN_N-1:0] PIN_IDLE = PIN_N'(1) << PIN_SEL;

  logic [PIN_N-1:0]  pins_raw, pins_s;
  logic              sclk_d, sclk_rise, sclk_fall, sel_act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, od_en;
  tx_req_t           tx_req;
  logic [CNT_W-1:0]  bit_cnt;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SDI]  = sdio_i;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_SEL]  = ssel_n_i;
  end

  spi3w_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= pins_s[PIN_SCLK];
  end

  assign sclk_rise = pins_s[PIN_SCLK] && !sclk_d;
  assign sclk_fall = !pins_s[PIN_SCLK] && sclk_d;
  assign sel_act   = !pins_s[PIN_SEL];

  spi3w_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .sel_act(sel_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi(pins_s[PIN_SDI]),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_req(tx_req), .bit_cnt(bit_cnt)
  );

  spi3w_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REGS(N_REGS), .GP_RST(GP_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .od_en(od_en)
  );

  spi3w_pad u_pad (
    .clk(clk), .rst(rst), .od_en(od_en), .tx_req(tx_req),
    .pad_o(sdio_o), .pad_oe(sdio_oe)
  );
endmodule

// File: rtl/spi3w_slave_chk.sv
module spi3w_slave_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_act,
  input logic             od_en,
  input logic             wr_en,
  input logic             sdio_o,
  input logic             sdio_oe,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_oe_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_act |-> ##2 !sdio_oe);

  assert_od_low_only_R7: assert property (@(posedge clk) disable iff (rst)
    (od_en && sdio_oe) |-> !sdio_o);

  assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> (bit_cnt == '0));

  assert_write_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sel_act));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!sdio_oe && bit_cnt == '0));
endmodule

bind spi3w_slave spi3w_slave_chk #(.CNT_W(4)) u_chk (
  .clk(clk), .rst(rst), .sel_act(sel_act), .od_en(od_en), .wr_en(wr_en),
  .sdio_o(sdio_o), .sdio_oe(sdio_oe), .bit_cnt(bit_cnt)
);

// File: tb/spi3w_slave_test.sv
module spi3w_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NGP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, ssel_n = 1'b1, mdrv_en = 1'b0, mdrv_val = 1'b0;
  wire  sdio_o, sdio_oe;
  wire  pin = sdio_oe ? sdio_o : (mdrv_en ? mdrv_val : 1'b1);

  spi3w_slave uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .ssel_n_i(ssel_n),
    .sdio_i(pin), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] val; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  int n_cmp = 0, n_bad = 0;
  logic od_tb = 1'b0;
  logic [7:0] gp_model [NGP];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] model_rd(input logic [6:0] a);
    if (a == 0) return {7'b0, od_tb};
    if (a < NGP) return gp_model[a];
    return 8'h00;
  endfunction

  task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
    if (a == 0) begin
      if (d[7]) begin
        od_tb = 1'b0;
        for (int i = 1; i < NGP; i++) gp_model[i] = 8'hA5;
      end else od_tb = d[0];
    end else if (a < NGP) gp_model[a] = d;
  endtask

  // Drives one frame; stop_at < 16 raises select before that bit
  task automatic xfer(input logic [6:0] addr, input logic rw, input logic [7:0] wd,
                      input int stop_at, output logic [7:0] rd);
    bit idle_bad = 0, drv_bad = 0;
    logic bitv;
    rd = '0;
    ssel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 16; i++) begin
      if (i == stop_at) break;
      sclk = 1'b0;
      if (i < 7)       begin mdrv_en = 1'b1; mdrv_val = addr[6-i]; end
      else if (i == 7) begin mdrv_en = 1'b1; mdrv_val = rw; end
      else if (!rw)    begin mdrv_en = 1'b1; mdrv_val = wd[15-i]; end
      else             mdrv_en = 1'b0;
      wait_clk(HALF);
      bitv = pin;
      if ((i < 8 || !rw) && sdio_oe) idle_bad = 1;
      if (i >= 8 && rw) begin
        rd[15-i] = bitv;
        if (od_tb) begin
          if (sdio_oe !== ~bitv || (sdio_oe && sdio_o !== 1'b0)) drv_bad = 1;
        end else if (sdio_oe !== 1'b1) drv_bad = 1;
      end
      sclk = 1'b1;
      wait_clk(HALF);
    end
    ssel_n = 1'b1;
    mdrv_en = 1'b0;
    wait_clk(2);
    sclk = 1'b0;
    wait_clk(HALF);
    chk(!idle_bad, "R4 enable off in address/write phase", {7'b0, idle_bad}, 8'h00);
    chk(sdio_oe == 1'b0, "R4 enable off with select high", {7'b0, sdio_oe}, 8'h00);
    if (rw && stop_at > 15)
      chk(!drv_bad, od_tb ? "R7 open-drain pull-low only" : "R3 push-pull drive in data phase",
          {7'b0, drv_bad}, 8'h00);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer(a, 1'b0, d, 16, dummy);
    model_wr(a, d);
  endtask

  task automatic rdx(input logic [6:0] a, input string tag);
    logic [7:0] got;
    item_t it;
    it.val = model_rd(a);
    it.tag = tag;
    exp_q.push_back(it);
    xfer(a, 1'b1, 8'h00, 16, got);
    act_q.push_back(got);
  endtask

  // Scoreboard monitor
  initial begin
    item_t e;
    logic [7:0] a;
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        a = act_q.pop_front();
        e = exp_q.pop_front();
        chk(a === e.val, e.tag, a, e.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    for (int i = 1; i < NGP; i++) gp_model[i] = 8'hA5;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk(sdio_oe == 1'b0, "R10 enable low after reset", {7'b0, sdio_oe}, 8'h00);
    rdx(7'h00, "R10 control reset value");
    rdx(7'h01, "R10 general reset value");

    // Writes and reads with varied patterns
    wr(7'h01, 8'h3C);
    wr(7'h02, 8'h81);
    wr(7'h03, 8'h5A);
    rdx(7'h01, "R1 R2 R3 readback reg1");
    rdx(7'h02, "R1 R2 R3 readback reg2");
    rdx(7'h03, "R1 R2 R3 readback reg3");

    // Unimplemented addresses
    wr(7'h40, 8'hFF);
    wr(7'h41, 8'hE7);
    rdx(7'h40, "R9 unimplemented reads zero");
    rdx(7'h7F, "R9 top address reads zero");
    rdx(7'h01, "R9 no alias onto reg1");

    // Cancelled write in data phase, cancelled frame in address phase
    xfer(7'h01, 1'b0, 8'h00, 12, junk);
    rdx(7'h01, "R5 aborted write leaves reg1");
    xfer(7'h03, 1'b0, 8'hFF, 3, junk);
    wr(7'h03, 8'h11);
    rdx(7'h03, "R5 fresh frame after abort");

    // Clocking and select toggling while deselected
    for (int k = 0; k < 10; k++) begin
      mdrv_en = 1'b1; mdrv_val = k[0];
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
    mdrv_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      ssel_n = 1'b0; wait_clk(HALF);
      ssel_n = 1'b1; wait_clk(HALF);
    end
    rdx(7'h02, "R6 reg2 kept over select toggles");
    rdx(7'h03, "R6 reg3 kept over select toggles");

    // Open-drain mode
    wr(7'h00, 8'h01);
    rdx(7'h00, "R7 open-drain bit reads back");
    rdx(7'h01, "R7 open-drain read reg1");
    rdx(7'h02, "R7 open-drain read reg2");

    // Software reset
    wr(7'h02, 8'h00);
    wr(7'h00, 8'h80);
    rdx(7'h00, "R8 control cleared, reset bit reads 0");
    rdx(7'h01, "R8 reg1 back to reset value");
    rdx(7'h02, "R8 reg2 back to reset value");
    rdx(7'h03, "R8 reg3 back to reset value");

    wait (act_q.size() == 0);
    wait_clk(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule